// File: doc/BRIEF.md
# Masked Chip-Select Decoder and Timer

This block steers external bus accesses to one of four memory or peripheral banks. Each bank has a base register and an option register. The base register holds a reference value for the upper address bits, a reference address-type code and an enable bit. The option register holds a per-bit address mask, a per-bit type mask and the strobe timing controls. The mask bits may form any pattern, so one bank can answer in several separate regions of the address map. The mask also lets one bank cover several kinds of access.

The block runs on a fast clock that divides each bus clock into four quarter ticks, numbered 0 to 3. The tick number appears on `bus_phase`. A bus request is taken at the end of a bus clock (tick 3). The access then occupies the next four ticks. The chip-select and write-enable strobes are registered on the quarter ticks. The option register sets the tick on which they assert and whether they release a quarter early.

After reset, bank 0 is enabled with an all-zero mask. It therefore answers every address, which gives a boot region until software programs the banks.

Top module: `msk_cs_unit`

## Requirements
- R1: Bank i hits when its base enable (base bit 0) is 1, and `bus_addr[31:15]` equals base bits [31:15] in every position where option bits [31:15] are 1. Positions where the mask bit is 0 are ignored, and address bits [14:0] never take part.
- R2: Any mask pattern is accepted, non-contiguous ones included, so a single bank can answer in several disjoint address regions.
- R3: `bus_type[2:0]` is compared with base bits [14:12] only where option bits [14:12] are 1. A type mask of zero ignores the type, and `bus_type[3]` never affects a hit.
- R4: When several banks hit, only the lowest-numbered one drives its `cs_n` bit low. At most one `cs_n` bit is ever low.
- R5: After reset, base bank 0 reads 32'h0000_0001 and every other register reads zero. Bank 0 then answers any address with a full four-tick strobe.
- R6: Option bits [2:1] set the assertion tick. Codes 00 and 01 assert on tick 0, code 10 asserts on tick 1 and code 11 asserts on tick 2.
- R7: When option bit 3 is 0, the strobes stay asserted through tick 3. When it is 1, they release one tick earlier and are high on tick 3.
- R8: `we_n` goes low only on write accesses. It follows exactly the same ticks as the selected `cs_n`.
- R9: An access that hits no bank leaves all strobes high.
- R10: Register reads return the stored fields with all unused bits zero. Base words are laid out as {addr[16:0], type[2:0], 11'b0, enable}. Option words are laid out as {mask[16:0], tmask[2:0], 8'b0, early, setup[1:0], 1'b0}. Register address bit 0 selects the option word, and bits [2:1] select the bank.
- R11: `bus_req` is sampled only on the clock edge that ends tick 3, and a request seen on any other tick is ignored. `bus_phase` advances by one on every clock and wraps from 3 to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Quarter-tick clock, four per bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register select: {bank, option/base} |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| bus_req | input | 1 | Access request, taken at the end of tick 3 |
| bus_addr | input | 32 | Access address |
| bus_type | input | 4 | Access type code; bit 3 ignored |
| bus_write | input | 1 | 1 for a write access |
| bus_phase | output | 2 | Current quarter tick |
| cs_n | output | 4 | Active-low chip-selects, one per bank |
| we_n | output | 1 | Active-low write-enable |

## Verification
A decode error, such as a mask bit applied with the wrong sense, a lost priority or a stale type compare, shows on `cs_n` in tick 0 of the very next access. The bench sweeps address and type patterns across overlapping banks and would see the wrong bank go low. A timing-field error, such as a wrong start or stop tick or a stale latched setting, shows within the four ticks of the same access. The bench compares the full per-tick strobe pattern, so an error of a single quarter tick is caught. A phase counter that drifts moves every later acceptance point, and this shows as strobes missing from their expected ticks.

// File: rtl/msk_cs_pkg.sv
package msk_cs_pkg;

  localparam int QTICKS = 4;

  // First tick on which strobes are driven for a setup code.
  function automatic logic [2:0] start_tick(input logic [1:0] setup);
    case (setup)
      2'b10:   start_tick = 3'd1;
      2'b11:   start_tick = 3'd2;
      default: start_tick = 3'd0;  // 00 and the spare code 01
    endcase
  endfunction

  // First tick on which strobes are released.
  function automatic logic [2:0] stop_tick(input logic early);
    stop_tick = early ? 3'd3 : 3'd4;
  endfunction

  function automatic logic in_window(input logic [1:0] ph, input logic [1:0] setup,
                                     input logic early);
    in_window = ({1'b0, ph} >= start_tick(setup)) && ({1'b0, ph} < stop_tick(early));
  endfunction

endpackage

// File: rtl/msk_cs_regs.sv
module msk_cs_regs #(
  parameter int NB     = 4,
  parameter int DATA_W = 32,
  parameter int MASK_W = 17,
  parameter int TYPE_W = 3,
  parameter int RA_W   = 3
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           we,
  input  logic [RA_W-1:0]                addr,
  input  logic [DATA_W-1:0]              wdata,
  output logic [DATA_W-1:0]              rdata,
  output logic [NB-1:0][MASK_W-1:0]      base_addr,
  output logic [NB-1:0][TYPE_W-1:0]      base_type,
  output logic [NB-1:0]                  base_val,
  output logic [NB-1:0][MASK_W-1:0]      opt_mask,
  output logic [NB-1:0][TYPE_W-1:0]      opt_tmask,
  output logic [NB-1:0]                  opt_early,
  output logic [NB-1:0][1:0]             opt_setup
);
  localparam int A_LSB = DATA_W - MASK_W;
  localparam int T_LSB = A_LSB - TYPE_W;
  localparam int BI_W  = RA_W - 1;

  logic [BI_W-1:0] sel_bank;
  logic            sel_opt;
  assign sel_bank = addr[RA_W-1:1];
  assign sel_opt  = addr[0];

  logic unused_wdata;
  assign unused_wdata = ^wdata[T_LSB-1:4];

  for (genvar i = 0; i < NB; i++) begin : g_bank
    logic hit_base, hit_opt;
    assign hit_base = we && !sel_opt && (sel_bank == BI_W'(i));
    assign hit_opt  = we &&  sel_opt && (sel_bank == BI_W'(i));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        base_addr[i] <= '0;
        base_type[i] <= '0;
        base_val[i]  <= (i == 0);   // boot bank enabled
      end else if (hit_base) begin
        base_addr[i] <= wdata[DATA_W-1:A_LSB];
        base_type[i] <= wdata[A_LSB-1:T_LSB];
        base_val[i]  <= wdata[0];
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        opt_mask[i]  <= '0;
        opt_tmask[i] <= '0;
        opt_early[i] <= 1'b0;
        opt_setup[i] <= 2'b00;
      end else if (hit_opt) begin
        opt_mask[i]  <= wdata[DATA_W-1:A_LSB];
        opt_tmask[i] <= wdata[A_LSB-1:T_LSB];
        opt_early[i] <= wdata[3];
        opt_setup[i] <= wdata[2:1];
      end
    end
  end

  always_comb begin
    rdata = '0;
    if (!sel_opt) begin
      rdata[DATA_W-1:A_LSB] = base_addr[sel_bank];
      rdata[A_LSB-1:T_LSB]  = base_type[sel_bank];
      rdata[0]              = base_val[sel_bank];
    end else begin
      rdata[DATA_W-1:A_LSB] = opt_mask[sel_bank];
      rdata[A_LSB-1:T_LSB]  = opt_tmask[sel_bank];
      rdata[3]              = opt_early[sel_bank];
      rdata[2:1]            = opt_setup[sel_bank];
    end
  end
endmodule

// File: rtl/msk_cs_match.sv
module msk_cs_match #(
  parameter int NB     = 4,
  parameter int MASK_W = 17,
  parameter int TYPE_W = 3
) (
  input  logic [MASK_W-1:0]              addr_hi,
  input  logic [TYPE_W-1:0]              atype,
  input  logic [NB-1:0][MASK_W-1:0]      base_addr,
  input  logic [NB-1:0][TYPE_W-1:0]      base_type,
  input  logic [NB-1:0]                  base_val,
  input  logic [NB-1:0][MASK_W-1:0]      opt_mask,
  input  logic [NB-1:0][TYPE_W-1:0]      opt_tmask,
  input  logic [NB-1:0]                  opt_early,
  input  logic [NB-1:0][1:0]             opt_setup,
  output logic [NB-1:0]                  grant,
  output logic [1:0]                     g_setup,
  output logic                           g_early
);
  logic [NB-1:0] hit;

  for (genvar i = 0; i < NB; i++) begin : g_cmp
    logic addr_ok, type_ok;
    assign addr_ok = (((addr_hi ^ base_addr[i]) & opt_mask[i]) == '0);
    assign type_ok = (((atype ^ base_type[i]) & opt_tmask[i]) == '0);
    assign hit[i]  = base_val[i] && addr_ok && type_ok;
  end

  // Isolate the lowest set hit bit.
  assign grant = hit & (~hit + {{(NB-1){1'b0}}, 1'b1});

  always_comb begin
    g_setup = 2'b00;
    g_early = 1'b0;
    for (int i = 0; i < NB; i++) begin
      g_setup = g_setup | ({2{grant[i]}} & opt_setup[i]);
      g_early = g_early | (grant[i] & opt_early[i]);
    end
  end
endmodule

// File: rtl/msk_cs_strobe.sv
module msk_cs_strobe
  import msk_cs_pkg::*;
#(
  parameter int NB = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req,
  input  logic          req_write,
  input  logic [NB-1:0] grant,
  input  logic [1:0]    g_setup,
  input  logic          g_early,
  output logic [1:0]    phase,
  output logic          active,
  output logic [1:0]    act_setup,
  output logic          act_early,
  output logic [NB-1:0] cs_n,
  output logic          we_n
);
  localparam logic [1:0] LAST_TICK = 2'(QTICKS - 1);

  logic [NB-1:0] bank_q, bank_d;
  logic          write_q, write_d;
  logic [1:0]    setup_d, phase_d;
  logic          early_d, active_d, accept, on_d;
  logic [NB-1:0] cs_n_d;
  logic          we_n_d;

  assign accept  = req && (phase == LAST_TICK);
  assign phase_d = phase + 2'd1;

  always_comb begin
    bank_d   = bank_q;
    write_d  = write_q;
    setup_d  = act_setup;
    early_d  = act_early;
    active_d = active;
    if (accept) begin
      bank_d   = grant;
      write_d  = req_write;
      setup_d  = g_setup;
      early_d  = g_early;
      active_d = |grant;
    end else if (phase == LAST_TICK) begin
      active_d = 1'b0;
    end
    on_d   = active_d && in_window(phase_d, setup_d, early_d);
    cs_n_d = on_d ? ~bank_d : '1;
    we_n_d = !(on_d && write_d);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase     <= 2'd0;
      active    <= 1'b0;
      bank_q    <= '0;
      write_q   <= 1'b0;
      act_setup <= 2'b00;
      act_early <= 1'b0;
      cs_n      <= '1;
      we_n      <= 1'b1;
    end else begin
      phase     <= phase_d;
      active    <= active_d;
      bank_q    <= bank_d;
      write_q   <= write_d;
      act_setup <= setup_d;
      act_early <= early_d;
      cs_n      <= cs_n_d;
      we_n      <= we_n_d;
    end
  end
endmodule

// File: rtl/msk_cs_unit.sv
module msk_cs_unit #(
  parameter int NUM_BANKS = 4,
  parameter int ADDR_W    = 32,
  parameter int DATA_W    = 32,
  parameter int MASK_W    = 17,
  parameter int TYPE_W    = 3
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           reg_we,
  input  logic [$clog2(NUM_BANKS):0]     reg_addr,
  input  logic [DATA_W-1:0]              reg_wdata,
  output logic [DATA_W-1:0]              reg_rdata,
  input  logic                           bus_req,
  input  logic [ADDR_W-1:0]              bus_addr,
  input  logic [TYPE_W:0]                bus_type,
  input  logic                           bus_write,
  output logic [1:0]                     bus_phase,
  output logic [NUM_BANKS-1:0]           cs_n,
  output logic                           we_n
);
  localparam int RA_W = $clog2(NUM_BANKS) + 1;

  logic [NUM_BANKS-1:0][MASK_W-1:0] base_addr, opt_mask;
  logic [NUM_BANKS-1:0][TYPE_W-1:0] base_type, opt_tmask;
  logic [NUM_BANKS-1:0]             base_val, opt_early;
  logic [NUM_BANKS-1:0][1:0]        opt_setup;

  logic [NUM_BANKS-1:0] grant;
  logic [1:0]           g_setup;
  logic                 g_early;

  // Named internal events, observed by the bound checker.
  logic                 cyc_active;
  logic [1:0]           cyc_setup;
  logic                 cyc_early;

  logic unused_bus;
  assign unused_bus = ^{bus_addr[ADDR_W-MASK_W-1:0], bus_type[TYPE_W]};

  msk_cs_regs #(
    .NB(NUM_BANKS), .DATA_W(DATA_W), .MASK_W(MASK_W), .TYPE_W(TYPE_W), .RA_W(RA_W)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
    .rdata(reg_rdata), .base_addr(base_addr), .base_type(base_type), .base_val(base_val),
    .opt_mask(opt_mask), .opt_tmask(opt_tmask), .opt_early(opt_early), .opt_setup(opt_setup)
  );

  msk_cs_match #(
    .NB(NUM_BANKS), .MASK_W(MASK_W), .TYPE_W(TYPE_W)
  ) u_match (
    .addr_hi(bus_addr[ADDR_W-1 -: MASK_W]), .atype(bus_type[TYPE_W-1:0]),
    .base_addr(base_addr), .base_type(base_type), .base_val(base_val),
    .opt_mask(opt_mask), .opt_tmask(opt_tmask), .opt_early(opt_early), .opt_setup(opt_setup),
    .grant(grant), .g_setup(g_setup), .g_early(g_early)
  );

  msk_cs_strobe #(
    .NB(NUM_BANKS)
  ) u_strobe (
    .clk(clk), .rst_n(rst_n), .req(bus_req), .req_write(bus_write),
    .grant(grant), .g_setup(g_setup), .g_early(g_early),
    .phase(bus_phase), .active(cyc_active), .act_setup(cyc_setup), .act_early(cyc_early),
    .cs_n(cs_n), .we_n(we_n)
  );
endmodule

// File: rtl/msk_cs_unit_chk.sv
module msk_cs_unit_chk #(
  parameter int NB = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic [NB-1:0] cs_n,
  input logic          we_n,
  input logic [1:0]    bus_phase,
  input logic          active,
  input logic [1:0]    setup,
  input logic          early
);
  a_r4_one_select: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~cs_n));

  a_r8_we_needs_cs: assert property (@(posedge clk) disable iff (!rst_n)
    !we_n |-> (~cs_n != '0));

  a_r7_early_release: assert property (@(posedge clk) disable iff (!rst_n)
    (active && early && bus_phase == 2'd3) |-> ((&cs_n) && we_n));

  a_r6_late_start: assert property (@(posedge clk) disable iff (!rst_n)
    (active && setup == 2'b11 && bus_phase <= 2'd1) |-> (&cs_n));

  a_r6_prompt_start: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !setup[1] && bus_phase == 2'd0) |-> (~cs_n != '0));

  a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !active |-> ((&cs_n) && we_n));

  a_r11_phase_step: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (bus_phase == 2'($past(bus_phase) + 2'd1)));
endmodule

bind msk_cs_unit msk_cs_unit_chk #(.NB(NUM_BANKS)) u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .we_n(we_n), .bus_phase(bus_phase),
  .active(cyc_active), .setup(cyc_setup), .early(cyc_early)
);

// File: tb/tb_msk_cs_unit.sv
module tb_msk_cs_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        bus_req = 1'b0;
  logic [31:0] bus_addr = '0;
  logic [3:0]  bus_type = '0;
  logic        bus_write = 1'b0;
  logic [1:0]  bus_phase;
  logic [3:0]  cs_n;
  logic        we_n;

  int n_chk = 0;
  int n_bad = 0;

  logic [16:0] sh_a[4], sh_m[4];
  logic [2:0]  sh_t[4], sh_tm[4];
  logic        sh_v[4], sh_e[4];
  logic [1:0]  sh_s[4];

  always #5 clk = ~clk;

  msk_cs_unit dut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .bus_req(bus_req), .bus_addr(bus_addr), .bus_type(bus_type),
    .bus_write(bus_write), .bus_phase(bus_phase), .cs_n(cs_n), .we_n(we_n)
  );

  task automatic report;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd_chk(input string tag, input logic [2:0] a, input logic [31:0] exp);
    @(negedge clk);
    reg_addr = a;
    #1 chk(tag, reg_rdata, exp);
  endtask

  task automatic set_base(input int i, input logic [16:0] a, input logic [2:0] t, input logic v);
    sh_a[i] = a; sh_t[i] = t; sh_v[i] = v;
    wr(3'(i * 2), {a, t, 11'b0, v});
  endtask

  task automatic set_opt(input int i, input logic [16:0] m, input logic [2:0] tm,
                         input logic e, input logic [1:0] s);
    sh_m[i] = m; sh_tm[i] = tm; sh_e[i] = e; sh_s[i] = s;
    wr(3'(i * 2 + 1), {m, tm, 8'b0, e, s, 1'b0});
  endtask

  // Bench model: first enabled bank whose masked fields agree, or -1.
  function automatic int pick(input logic [16:0] up, input logic [2:0] ty);
    for (int i = 0; i < 4; i++)
      if (sh_v[i] && ((up & sh_m[i]) == (sh_a[i] & sh_m[i])) &&
          ((ty & sh_tm[i]) == (sh_t[i] & sh_tm[i])))
        return i;
    return -1;
  endfunction

  function automatic logic tick_on(input int p, input logic [1:0] s, input logic e);
    int first, last;
    first = (s == 2'b11) ? 2 : ((s == 2'b10) ? 1 : 0);
    last  = e ? 2 : 3;
    return (p >= first) && (p <= last);
  endfunction

  // One access; compares the whole per-tick pattern of cs_n and we_n.
  task automatic access(input string tag, input logic [16:0] up, input logic [14:0] lo,
                        input logic [3:0] ty, input logic w);
    logic [19:0] got, exp;
    int b;
    @(negedge clk);
    while (bus_phase != 2'd3) @(negedge clk);
    bus_req = 1'b1; bus_addr = {up, lo}; bus_type = ty; bus_write = w;
    b = pick(up, ty[2:0]);
    got = '0; exp = '0;
    for (int p = 0; p < 4; p++) begin
      @(negedge clk);
      if (p == 0) bus_req = 1'b0;
      got[p*5 +: 5] = {we_n, cs_n};
      if (b >= 0 && tick_on(p, sh_s[b], sh_e[b]))
        exp[p*5 +: 5] = {!w, 4'b1111 & ~(4'b0001 << b)};
      else
        exp[p*5 +: 5] = 5'b11111;
    end
    chk(tag, {12'b0, got}, {12'b0, exp});
  endtask

  initial begin
    #(200000 * 10);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    report();
  end

  initial begin
    logic [16:0] up;
    for (int i = 0; i < 4; i++) begin
      sh_a[i] = '0; sh_t[i] = '0; sh_v[i] = (i == 0); sh_m[i] = '0;
      sh_tm[i] = '0; sh_e[i] = 1'b0; sh_s[i] = 2'b00;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R5: reset contents and boot-bank behaviour
    chk("R5 strobes idle", {27'b0, we_n, cs_n}, 32'h1F);
    rd_chk("R5 base0", 3'd0, 32'h0000_0001);
    for (int a = 1; a < 8; a++) rd_chk("R5 other reg", 3'(a), 32'h0);
    access("R5 boot bank any address", 17'h1A5C3, 15'h3F21, 4'hB, 1'b1);
    access("R5 boot bank read", 17'h00001, 15'h0, 4'h0, 1'b0);

    // R10: unused bits read as zero
    wr(3'd3, 32'hFFFF_FFFF);
    rd_chk("R10 option fields", 3'd3, 32'hFFFF_F00E);
    wr(3'd2, 32'hFFFF_FFFF);
    rd_chk("R10 base fields", 3'd2, 32'hFFFF_F001);
    wr(3'd5, 32'h1234_5678);
    rd_chk("R10 option pattern", 3'd5, 32'h1234_5008);

    // Overlapping configuration: R1 contiguous, R2 non-contiguous, R3 type
    set_base(0, 17'h00000, 3'b000, 1'b1);
    set_base(1, 17'h08000, 3'b000, 1'b1);
    set_base(2, 17'h00101, 3'b000, 1'b1);
    set_base(3, 17'h00000, 3'b100, 1'b1);

    for (int sc = 0; sc < 8; sc++) begin
      set_opt(0, 17'h1FFFF, 3'b000, sc[2] ^ 1'b0, 2'(sc));
      set_opt(1, 17'h18000, 3'b000, sc[2] ^ 1'b1, 2'(sc + 1));
      set_opt(2, 17'h00109, 3'b000, sc[2] ^ 1'b0, 2'(sc + 2));
      set_opt(3, 17'h00000, 3'b101, sc[2] ^ 1'b1, 2'(sc + 3));
      for (int k = 0; k < 64; k++) begin
        up = '0;
        up[16] = k[5]; up[15] = k[4]; up[8] = k[3];
        up[3] = k[2];  up[0] = k[1];  up[1] = k[0];
        for (int ty = 0; ty < 16; ty++)
          access("R1 R2 R3 R4 R6 R7 R8 R9 sweep", up, 15'(k * 37 + ty), 4'(ty),
                 k[0] ^ ty[0]);
      end
    end

    // R9: no enabled bank hits
    set_base(0, 17'h00000, 3'b000, 1'b0);
    access("R9 no hit", 17'h00000, 15'h0, 4'h0, 1'b1);

    // R11: a request outside tick 3 is ignored
    set_base(0, 17'h00000, 3'b000, 1'b1);
    set_opt(0, 17'h00000, 3'b000, 1'b0, 2'b00);
    @(negedge clk);
    while (bus_phase != 2'd1) @(negedge clk);
    bus_req = 1'b1; bus_write = 1'b1;
    @(negedge clk);
    bus_req = 1'b0;
    for (int p = 0; p < 8; p++) begin
      @(negedge clk);
      chk("R11 off-tick request ignored", {27'b0, we_n, cs_n}, 32'h1F);
    end
    access("R11 on-tick request taken", 17'h0ABCD, 15'h0, 4'h0, 1'b0);

    report();
  end
endmodule